// File: doc/BRIEF.md
# Four-Phase Event Synchronizer

This block sits between a set of external agents, each owning one event, and a group of path sequencers that each enforce an ordering over a subset of those events. Every event has its own request/acknowledge pair that follows a four-phase handshake. An event's request is forwarded to an external exclusion arbiter only when every sequencer that lists the event reports it as allowed, and the event is acknowledged only after the arbiter grants it. The acknowledge is also fanned out as the sequencer request line of every path that contains the event.

Completion is tracked per event by a clear flag that behaves as a C-element. It rises once every member sequencer has acknowledged and the agent has withdrawn its request. It falls once every member sequencer has withdrawn its acknowledge. While the flag is high it forces the event's acknowledge low, and it stops both the event itself and every conflicting event from presenting a new arbiter request. Two events conflict when some path contains both of them. The membership of events in paths is a compile-time bit-matrix parameter, and the conflict relation is derived from it. All state is clocked on one edge.

Top module: `event_sync`

## Requirements
- R1: `ack[e]` rises only on a cycle after `req[e]` was high, and falls only after `req[e]` has been seen low since it rose. While `req[e]` stays high, a raised `ack[e]` stays high.
- R2: A request that is permitted reaches `arb_req[e]` one clock after `req[e]` is sampled high. A grant that is present while `arb_req[e]` is high yields `ack[e]` one clock later.
- R3: `arb_req[e]` rises only if `req[e]` is high and every path whose membership bit `MEMBER[p*N_EV+e]` is set holds `seq_dis[p*N_EV+e]` low. The `seq_dis` bits of paths that do not contain the event have no effect. Once `ack[e]` is high, `arb_req[e]` stays high until `req[e]` falls.
- R4: `arb_req[e]` does not rise while the clear flag of the event itself, or of any conflicting event, is high.
- R5: `seq_tr[p*N_EV+e]` equals `ack[e]` when path p contains event e, and is 0 otherwise.
- R6: The clear flag of an event is set one clock after all member `seq_ta` bits are high while `req[e]` is low. It is cleared one clock after all member `seq_ta` bits are low. Otherwise it holds its value. A conflicting request therefore reaches the arbiter two clocks after the last member TA falls.
- R7: A high clear flag drives `ack[e]` low on the next clock.
- R8: Two conflicting events are never acknowledged in the same cycle. If both qualify for acknowledge in the same cycle, the lower-numbered event wins.
- R9: During reset `ack`, `arb_req` and `seq_tr` are all 0 and every clear flag is 1. Because of this, a request held across reset release is not forwarded on the first clock.
- R10: Events that share no path may be acknowledged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N_EV | Per-event request from the agents |
| ack | output | N_EV | Per-event acknowledge to the agents |
| arb_req | output | N_EV | Per-event request to the exclusion arbiter |
| arb_gnt | input | N_EV | Per-event grant from the arbiter |
| seq_tr | output | N_PATH*N_EV | Sequencer request lines, bit p*N_EV+e |
| seq_ta | input | N_PATH*N_EV | Sequencer acknowledge lines, bit p*N_EV+e |
| seq_dis | input | N_PATH*N_EV | Sequencer disable lines, bit p*N_EV+e |

## Verification
Each result has a fixed latency. `arb_req` follows a permitted request by one clock. `ack` follows a grant by one clock. The clear flag follows its TA/REQ condition by one clock, and `ack` drops one clock after that. A conflicting request returns to the arbiter two clocks after the last member TA falls. The bench drives inputs on the falling edge and samples on the next falling edge. The directed cases count those edges exactly: a request held over reset release, DIS blocking and unblocking, two simultaneous conflicting requests, two concurrent independent events, and a request made while a clear flag is pending. In the random phase the legal agents, a masking arbiter and sequencer models that enforce orderings run together, and every cycle is checked for exclusion, handshake order, TR routing, path order and bounded waiting.

// File: rtl/event_sync_pkg.sv
package event_sync_pkg;
  localparam int MAX_EV   = 32;
  localparam int MAX_BITS = 1024;

  typedef logic [MAX_BITS-1:0] member_t;
  typedef logic [MAX_EV-1:0]   evmask_t;

  // Events conflict when at least one path lists both of them.
  function automatic evmask_t conflict_row(input member_t mem, input int n_ev,
                                           input int n_path, input int e);
    evmask_t r = '0;
    for (int p = 0; p < n_path; p++)
      if (mem[p*n_ev+e])
        for (int f = 0; f < n_ev; f++)
          if (mem[p*n_ev+f]) r[f] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/event_sync_admit.sv
module event_sync_admit (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic held,
  input  logic dis_ok,
  input  logic blk,
  output logic arb
);
  logic arb_d;

  // A request that is already acknowledged keeps its arbiter line, so the
  // DIS lines, which are only valid between cycles, cannot drop it.
  assign arb_d = req & (held | (dis_ok & ~blk));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) arb <= 1'b0;
    else        arb <= arb_d;

  a_r3_rise_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb) |-> $past(req) && $past(dis_ok));
  a_r4_rise_not_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(arb) && !$past(held)) |-> !$past(blk));
endmodule

// File: rtl/event_sync_celem.sv
module event_sync_celem (
  input  logic clk,
  input  logic rst_n,
  input  logic all_hi,
  input  logic all_lo,
  input  logic req,
  output logic clr
);
  logic set_c;

  assign set_c = all_hi & ~req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      clr <= 1'b1;
    else if (set_c)  clr <= 1'b1;
    else if (all_lo) clr <= 1'b0;

  a_r6_rise_after_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr) |-> !$past(req));
  a_r6_fall_after_ta_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr) |-> $past(all_lo));
endmodule

// File: rtl/event_sync.sv
module event_sync #(
  parameter int N_EV   = 4,
  parameter int N_PATH = 3,
  parameter logic [N_PATH*N_EV-1:0] MEMBER = 12'h863
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_EV-1:0]        req,
  output logic [N_EV-1:0]        ack,
  output logic [N_EV-1:0]        arb_req,
  input  logic [N_EV-1:0]        arb_gnt,
  output logic [N_PATH*N_EV-1:0] seq_tr,
  input  logic [N_PATH*N_EV-1:0] seq_ta,
  input  logic [N_PATH*N_EV-1:0] seq_dis
);
  import event_sync_pkg::*;

  logic [N_EV-1:0] ack_q, ack_d, clr_q, blk, ack_blk, cand, win;
  logic [N_EV-1:0] dis_ok, all_hi, all_lo;

  for (genvar e = 0; e < N_EV; e++) begin : g_ev
    localparam evmask_t ROW = conflict_row(member_t'(MEMBER), N_EV, N_PATH, e);
    localparam logic [N_EV-1:0] CONF = ROW[N_EV-1:0];
    localparam logic [N_EV-1:0] SELF = N_EV'(1) << e;
    localparam logic [N_EV-1:0] LOW  = SELF - N_EV'(1);

    logic [N_PATH-1:0] c_dis, c_ta, c_mem;

    for (genvar p = 0; p < N_PATH; p++) begin : g_p
      assign c_dis[p] = seq_dis[p*N_EV+e];
      assign c_ta[p]  = seq_ta[p*N_EV+e];
      assign c_mem[p] = MEMBER[p*N_EV+e];
      assign seq_tr[p*N_EV+e] = MEMBER[p*N_EV+e] & ack_q[e];
    end

    // Wired-NOR of member DIS lines and AND/NOR views of member TA lines.
    assign dis_ok[e] = ~|(c_dis & c_mem);
    assign all_hi[e] = &(c_ta | ~c_mem);
    assign all_lo[e] = ~|(c_ta & c_mem);

    assign blk[e]     = clr_q[e] | (|(clr_q & CONF));
    assign ack_blk[e] = |(ack_q & CONF & ~SELF);
    assign cand[e]    = arb_gnt[e] & arb_req[e] & req[e] & ~blk[e] & ~ack_blk[e];
    assign win[e]     = cand[e] & ~|(cand & CONF & LOW);
    assign ack_d[e]   = ~clr_q[e] & (ack_q[e] | win[e]);

    event_sync_admit i_admit (
      .clk(clk), .rst_n(rst_n), .req(req[e]), .held(ack_q[e]),
      .dis_ok(dis_ok[e]), .blk(blk[e]), .arb(arb_req[e]));

    event_sync_celem i_celem (
      .clk(clk), .rst_n(rst_n), .all_hi(all_hi[e]), .all_lo(all_lo[e]),
      .req(req[e]), .clr(clr_q[e]));

    a_r1_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q[e]) |-> $past(req[e]));
    a_r7_clr_drops_ack: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q[e] |=> !ack_q[e]);

    for (genvar f = e + 1; f < N_EV; f++) begin : g_pair
      if (CONF[f]) begin : g_conf
        a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
          !(ack_q[e] && ack_q[f]));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ack_q <= '0;
    else        ack_q <= ack_d;

  assign ack = ack_q;
endmodule

// File: tb/test_event_sync.sv
module test_event_sync;
  localparam int NE = 4, NP = 3, NB = NE*NP;
  localparam logic [NB-1:0] MEM = 12'h863;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] req = '0, ack, arb_req, arb_gnt, gmask = '1;
  logic [NB-1:0] seq_tr, seq_ta, seq_dis, junk = '0;
  logic free = 1'b1;
  logic [NP-1:0] st;
  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  event_sync #(.N_EV(NE), .N_PATH(NP), .MEMBER(MEM)) i_event_sync (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .arb_req(arb_req),
    .arb_gnt(arb_gnt), .seq_tr(seq_tr), .seq_ta(seq_ta), .seq_dis(seq_dis));

  assign arb_gnt = arb_req & gmask;

  // Sequencer models: path0 alternates 0,1; path1 alternates 1,2; path2 runs 3.
  function automatic int exp_ev(input int p, input logic s);
    if (p == 0) return s ? 1 : 0;
    if (p == 1) return s ? 2 : 1;
    return 3;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin seq_ta <= '0; st <= '0; end
    else begin
      seq_ta <= seq_tr;
      for (int p = 0; p < NP; p++)
        if ((seq_tr[p*NE +: NE] & ~seq_ta[p*NE +: NE]) != '0) st[p] <= ~st[p];
    end

  always_comb
    for (int p = 0; p < NP; p++)
      for (int e = 0; e < NE; e++)
        seq_dis[p*NE+e] = free ? junk[p*NE+e] : (MEM[p*NE+e] && e != exp_ev(p, st[p]));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  logic [NE-1:0] prev_req, prev_ack, drop_seen;
  logic [NB-1:0] prev_tr;
  int wait_cnt [NE];

  initial begin
    // R9: reset state, request held across release
    step(); step();
    req[0] = 1'b1; step();
    chk(ack == 0 && arb_req == 0 && seq_tr == 0, "R9 reset outputs", int'(ack), 0);
    rst_n = 1'b1; step();
    chk(arb_req[0] == 1'b0, "R9 clr high blocks first clock", arb_req[0], 0);
    step();
    chk(arb_req[0] == 1'b1, "R2 arb one clock after req", arb_req[0], 1);
    step();
    chk(ack == 4'b0001, "R2 ack one clock after grant", int'(ack), 1);
    chk(seq_tr == 12'h001, "R5 tr routed to path0 only", int'(seq_tr), 1);
    step();
    req[0] = 1'b0; step();
    chk(ack[0] == 1'b1, "R1 ack held until clr", ack[0], 1);
    req[1] = 1'b1; step();
    chk(ack[0] == 1'b0, "R7 clr drops ack", ack[0], 0);
    chk(arb_req[1] == 1'b0, "R4 conflicting clr blocks", arb_req[1], 0);
    step();
    chk(arb_req[1] == 1'b0, "R4 still blocked", arb_req[1], 0);
    step();
    chk(arb_req[1] == 1'b0, "R6 clr falls after TA low", arb_req[1], 0);
    step();
    chk(arb_req[1] == 1'b1, "R6 request released", arb_req[1], 1);
    step();
    chk(ack[1] == 1'b1, "R2 ack of event1", ack[1], 1);
    req[1] = 1'b0; repeat (10) step();

    // R3: member DIS blocks, non-member DIS ignored; R10 concurrency
    junk = 12'h140; req[2] = 1'b1;
    repeat (3) step();
    chk(arb_req[2] == 1'b0, "R3 member DIS blocks", arb_req[2], 0);
    junk = 12'h100; req[0] = 1'b1; step();
    chk(arb_req == 4'b0101, "R3 non-member DIS ignored", int'(arb_req), 5);
    step();
    chk(ack == 4'b0101, "R10 independent events together", int'(ack), 5);
    junk = 12'h040; step();
    chk(arb_req == 4'b0101, "R3 arb held while acked", int'(arb_req), 5);
    req[0] = 1'b0; req[2] = 1'b0; junk = '0; repeat (10) step();

    // R8: simultaneous conflicting requests
    req[0] = 1'b1; req[1] = 1'b1; step();
    chk(arb_req[1:0] == 2'b11, "R8 both at arbiter", int'(arb_req[1:0]), 3);
    step();
    chk(ack[1:0] == 2'b01, "R8 lower index wins", int'(ack[1:0]), 1);
    req[0] = 1'b0;
    for (int i = 0; i < 20 && !ack[1]; i++) begin
      chk(!(ack[0] && ack[1]), "R8 no overlap", int'(ack[1:0]), 1);
      step();
    end
    chk(ack[1:0] == 2'b10, "R8 loser served later", int'(ack[1:0]), 2);
    req[1] = 1'b0; repeat (10) step();

    // Random phase with ordering sequencers
    rst_n = 1'b0; free = 1'b0; step(); rst_n = 1'b1; step();
    prev_req = req; prev_ack = ack; prev_tr = seq_tr; drop_seen = '0;
    for (int e = 0; e < NE; e++) wait_cnt[e] = 0;
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < NE; i++)
        for (int j = i + 1; j < NE; j++)
          if ((MEM[i] && MEM[j]) || (MEM[NE+i] && MEM[NE+j]) || (MEM[2*NE+i] && MEM[2*NE+j]))
            chk(!(ack[i] && ack[j]), "R8 random exclusion", int'(ack), 0);
      for (int p = 0; p < NP; p++)
        for (int e = 0; e < NE; e++) begin
          chk(seq_tr[p*NE+e] == (MEM[p*NE+e] & ack[e]), "R5 tr routing", seq_tr[p*NE+e], int'(MEM[p*NE+e] & ack[e]));
          if (seq_tr[p*NE+e] && !prev_tr[p*NE+e])
            chk(e == exp_ev(p, st[p]), "R3 path order", e, exp_ev(p, st[p]));
        end
      for (int e = 0; e < NE; e++) begin
        if (ack[e] && !prev_ack[e]) begin
          chk(prev_req[e], "R1 ack rise needs req", prev_req[e], 1);
          drop_seen[e] = 1'b0;
        end
        if (!ack[e] && prev_ack[e]) chk(drop_seen[e], "R1 ack fall after withdraw", drop_seen[e], 1);
        if (prev_ack[e] && prev_req[e] && !drop_seen[e]) chk(ack[e], "R1 ack held", ack[e], 1);
        wait_cnt[e] = (req[e] && !ack[e]) ? wait_cnt[e] + 1 : 0;
        chk(wait_cnt[e] < 300, "R2 bounded wait", wait_cnt[e], 0);
      end
      prev_ack = ack; prev_tr = seq_tr;
      for (int e = 0; e < NE; e++) begin
        if (!req[e] && !ack[e] && c < 3800 && ($urandom % 4) == 0) req[e] = 1'b1;
        else if (req[e] && ack[e] && ($urandom % 3) == 0) req[e] = 1'b0;
        if (ack[e] && !req[e]) drop_seen[e] = 1'b1;
      end
      gmask = NE'($urandom) | NE'($urandom);
      prev_req = req;
      step();
    end
    chk(ack == 0 && arb_req == 0 && req == 0, "R1 drained", int'(ack), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial void'($urandom(32'd4711));
endmodule